// File: doc/BRIEF.md
# Bridge Legacy Video Window Decoder

This block decides, for each transaction seen by a bus bridge, whether the bridge claims it because it falls in one of the fixed legacy video address regions. Three regions are recognised: a memory frame-buffer window, a set of I/O register port ranges, and three colour-palette I/O ports. The I/O ranges decode only the low ten address bits inside the 64 KiB I/O space, so every alias repeated through the upper I/O bits matches as well.

Two configuration bits select the policy: a window enable that claims every legacy access travelling downstream and blocks the same accesses from travelling upstream, and a palette-forward bit that, with the window enable clear, claims only palette writes heading downstream so a graphics agent below the bridge can observe them. Both bits clear at reset and are loaded through a one-cycle write strobe. Each request pulse produces a registered decision, with a range code, exactly one clock later.

Top module: `lvd_top`

## Requirements
- R1: A memory request (space flag 0) whose full 32-bit address lies in 0x000A0000..0x000BFFFF reports range code 2'b01; every other memory address, including the ROM area from 0x000C0000 upward and addresses with any of bits [31:20] set, reports 2'b00.
- R2: An I/O request (space flag 1) with address below 0x10000 whose bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF, and are not a palette port, reports range code 2'b10, whatever bits [15:10] hold.
- R3: An I/O request below 0x10000 whose bits [9:0] equal 0x3C6, 0x3C8 or 0x3C9 reports range code 2'b11 (palette takes priority over the register ranges), whatever bits [15:10] hold.
- R4: An I/O request with any of bits [31:16] set reports range code 2'b00, and a memory request never reports 2'b10 or 2'b11.
- R5: With the window enable (config bit 0) at 1, a request from the upstream side (direction flag 0) with a nonzero range code asserts forward for reads and writes alike, regardless of config bit 1.
- R6: With config bit 0 at 0 and config bit 1 at 1, forward is asserted only for upstream palette writes; palette reads and all other ranges are not forwarded and nothing is blocked.
- R7: With both config bits at 0, neither forward nor block is ever asserted.
- R8: With config bit 0 at 1, a request from the downstream side (direction flag 1) with a nonzero range code asserts block and never forward; with config bit 0 at 0 block stays low.
- R9: Both config bits are 0 after reset; a write strobe loads data bit 0 into the window enable and bit 1 into the palette-forward bit, and a request in the same cycle as the write still uses the previous values.
- R10: Forward, block and range code are valid in the cycle after a request pulse and are all zero in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0 window enable, bit 1 palette forward |
| req_valid | input | 1 | One-cycle request pulse |
| req_addr | input | 32 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_from_dn | input | 1 | 1 = arrived on the downstream side, 0 = upstream side |
| dec_fwd | output | 1 | Claim and forward downstream |
| dec_blk | output | 1 | Block from going upstream |
| dec_range | output | 2 | 00 none, 01 frame buffer, 10 register ports, 11 palette |

## Verification
The bench sweeps all 1024 low I/O offsets under every config setting, direction and read/write combination with the alias bits varied, so a decoder that compared bits [15:10], mis-set a range edge such as 0x3BB/0x3BC or 0x3DF/0x3E0, or let the register range hide the palette code would report a wrong range code. Memory addresses are stepped across 0x9FFFF/0xA0000 and 0xBFFFF/0xC0000 and given high bits, catching an off-by-one window or a decoder that also claimed ROM space. Policy checks catch a design that forwarded palette reads in palette-only mode, forwarded or failed to block traffic from the downstream side, or applied a config write one cycle early.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

  typedef enum logic [1:0] {
    RNG_NONE = 2'b00,
    RNG_FBUF = 2'b01,
    RNG_PORT = 2'b10,
    RNG_PAL  = 2'b11
  } lvd_range_e;

  typedef struct packed {
    logic pal_fwd;
    logic win_en;
  } lvd_ctrl_t;

  typedef struct packed {
    logic       fwd;
    logic       blk;
    lvd_range_e rng;
  } lvd_dec_t;

endpackage

// File: rtl/lvd_rst_sync.sv
module lvd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lvd_ctrl_regs.sv
module lvd_ctrl_regs
  import lvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output lvd_ctrl_t  ctrl
);
  lvd_ctrl_t ctrl_q;
  lvd_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.win_en  = wdata[0];
      ctrl_d.pal_fwd = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R9: a write lands on the following edge, bit order fixed
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctrl_q.win_en == $past(wdata[0]) && ctrl_q.pal_fwd == $past(wdata[1])));

  a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q));
endmodule

// File: rtl/lvd_range_match.sv
module lvd_range_match
  import lvd_pkg::*;
#(
  parameter int                 ADDR_W  = 32,
  parameter int                 IO_W    = 16,
  parameter int                 ALIAS_W = 10,
  parameter logic [ADDR_W-1:0]  FB_LO   = 32'h000A_0000,
  parameter logic [ADDR_W-1:0]  FB_HI   = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  output lvd_range_e        rng
);
  localparam int N_PORT_RNG = 2;
  localparam int N_PAL      = 3;
  localparam int HI_W       = ADDR_W - IO_W;

  localparam logic [ALIAS_W-1:0] PORT_LO [N_PORT_RNG] = '{ALIAS_W'('h3B0), ALIAS_W'('h3C0)};
  localparam logic [ALIAS_W-1:0] PORT_HI [N_PORT_RNG] = '{ALIAS_W'('h3BB), ALIAS_W'('h3DF)};
  localparam logic [ALIAS_W-1:0] PAL_PT  [N_PAL]      = '{ALIAS_W'('h3C6), ALIAS_W'('h3C8), ALIAS_W'('h3C9)};

  logic [ALIAS_W-1:0]    ofs;
  logic                  io_space_ok;
  logic [N_PORT_RNG-1:0] port_hit_v;
  logic [N_PAL-1:0]      pal_hit_v;
  logic                  fb_hit;

  assign ofs         = addr[ALIAS_W-1:0];
  assign io_space_ok = (addr[ADDR_W-1:IO_W] == HI_W'(0));
  assign fb_hit      = (addr >= FB_LO) && (addr <= FB_HI);

  for (genvar g = 0; g < N_PORT_RNG; g++) begin : g_port
    assign port_hit_v[g] = (ofs >= PORT_LO[g]) && (ofs <= PORT_HI[g]);
  end

  for (genvar p = 0; p < N_PAL; p++) begin : g_pal
    assign pal_hit_v[p] = (ofs == PAL_PT[p]);
  end

  always_comb begin
    rng = RNG_NONE;
    if (!is_io) begin
      if (fb_hit) rng = RNG_FBUF;
    end else if (io_space_ok) begin
      if (|pal_hit_v)       rng = RNG_PAL;
      else if (|port_hit_v) rng = RNG_PORT;
    end
  end

  // R4: I/O above the 64 KiB space never matches
  a_r4_io_high_none: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io && !io_space_ok) |-> (rng == RNG_NONE));

  // R4: memory requests never report an I/O range code
  a_r4_mem_no_io_code: assert property (@(posedge clk) disable iff (!rst_n)
    !is_io |-> (rng == RNG_NONE || rng == RNG_FBUF));

  // R1: the ROM area just above the window is never decoded
  a_r1_rom_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_io && addr > FB_HI) |-> (rng == RNG_NONE));

  // R3: a palette code always lies inside a register range
  a_r3_pal_inside_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == RNG_PAL) |-> (|port_hit_v));
endmodule

// File: rtl/lvd_policy.sv
module lvd_policy
  import lvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lvd_ctrl_t  ctrl,
  input  lvd_range_e rng,
  input  logic       is_wr,
  input  logic       from_dn,
  output logic       fwd,
  output logic       blk
);
  logic hit;

  assign hit = (rng != RNG_NONE);

  always_comb begin
    fwd = 1'b0;
    blk = 1'b0;
    if (hit) begin
      if (from_dn) begin
        blk = ctrl.win_en;
      end else if (ctrl.win_en) begin
        fwd = 1'b1;
      end else if (ctrl.pal_fwd && (rng == RNG_PAL) && is_wr) begin
        fwd = 1'b1;
      end
    end
  end

  // R7: both bits clear means complete silence
  a_r7_both_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.win_en && !ctrl.pal_fwd) |-> (!fwd && !blk));

  // R6: palette-only mode forwards upstream palette writes only
  a_r6_pal_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.win_en && fwd) |-> (rng == RNG_PAL && is_wr && !from_dn));

  // R8: downstream-side traffic is never sent downstream
  a_r8_dn_never_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    from_dn |-> !fwd);

  // R8: blocking needs the window enable
  a_r8_blk_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> ctrl.win_en);
endmodule

// File: rtl/lvd_top.sv
module lvd_top
  import lvd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IO_W    = 16,
  parameter int ALIAS_W = 10,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_is_wr,
  input  logic              req_from_dn,
  output logic              dec_fwd,
  output logic              dec_blk,
  output logic [1:0]        dec_range
);
  logic       rst_n_s;
  lvd_ctrl_t  ctrl;
  lvd_range_e rng_c;
  logic       fwd_c;
  logic       blk_c;
  lvd_dec_t   dec_d;
  lvd_dec_t   dec_q;

  lvd_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lvd_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctrl  (ctrl)
  );

  lvd_range_match #(
    .ADDR_W  (ADDR_W),
    .IO_W    (IO_W),
    .ALIAS_W (ALIAS_W)
  ) u_match (
    .clk   (clk),
    .rst_n (rst_n_s),
    .addr  (req_addr),
    .is_io (req_is_io),
    .rng   (rng_c)
  );

  lvd_policy u_pol (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ctrl    (ctrl),
    .rng     (rng_c),
    .is_wr   (req_is_wr),
    .from_dn (req_from_dn),
    .fwd     (fwd_c),
    .blk     (blk_c)
  );

  always_comb begin
    dec_d = '0;
    if (req_valid) begin
      dec_d.fwd = fwd_c;
      dec_d.blk = blk_c;
      dec_d.rng = rng_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) dec_q <= '0;
    else          dec_q <= dec_d;
  end

  assign dec_fwd   = dec_q.fwd;
  assign dec_blk   = dec_q.blk;
  assign dec_range = dec_q.rng;

  // R10: an idle cycle leaves every output low on the next one
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> (!dec_fwd && !dec_blk && dec_range == 2'b00));

  // R8: forward and block are never both set
  a_r8_fwd_blk_excl: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(dec_fwd && dec_blk));

  // R10: any decision implies a recognised range
  a_r10_decision_has_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dec_fwd || dec_blk) |-> (dec_range != 2'b00));
endmodule

// File: tb/lvd_top_tb_top.sv
module lvd_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_is_io;
  logic        req_is_wr;
  logic        req_from_dn;
  logic        dec_fwd;
  logic        dec_blk;
  logic [1:0]  dec_range;

  int n_chk;
  int n_fail;
  int cyc;
  logic [1:0] cfg_model;

  lvd_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_is_io   (req_is_io),
    .req_is_wr   (req_is_wr),
    .req_from_dn (req_from_dn),
    .dec_fwd     (dec_fwd),
    .dec_blk     (dec_blk),
    .dec_range   (dec_range)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] exp_rng(logic [31:0] a, logic io);
    int lo;
    if (!io) return (a >= 32'hA0000 && a <= 32'hBFFFF) ? 2'b01 : 2'b00;
    if (a >= 32'h10000) return 2'b00;
    lo = int'(a % 1024);
    if (lo == 'h3C6 || lo == 'h3C8 || lo == 'h3C9) return 2'b11;
    if ((lo >= 'h3B0 && lo <= 'h3BB) || (lo >= 'h3C0 && lo <= 'h3DF)) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual fwd/blk/rng=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cfg_write(logic [1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v;
  endtask

  task automatic do_req(logic [31:0] a, logic io, logic wr, logic dn);
    logic [1:0] r;
    logic ef, eb;
    string rtag, ptag;
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_is_wr = wr; req_from_dn = dn;
    @(negedge clk);
    req_valid = 1'b0;
    r  = exp_rng(a, io);
    ef = (r != 2'b00) && !dn && (cfg_model[0] || (cfg_model[1] && r == 2'b11 && wr));
    eb = (r != 2'b00) && dn && cfg_model[0];
    if (!io)               rtag = (a[31:20] != 0 || a[11:0] == 12'h3C8) ? "R4" : "R1";
    else if (a >= 'h10000) rtag = "R4";
    else if (r == 2'b11)   rtag = "R3";
    else                   rtag = "R2";
    if (cfg_model[0])      ptag = dn ? "R8" : "R5";
    else if (cfg_model[1]) ptag = "R6";
    else                   ptag = "R7";
    chk(rtag, {2'b00, dec_range}, {2'b00, r});
    chk(ptag, {dec_fwd, dec_blk, 2'b00}, {ef, eb, 2'b00});
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cfg_model = 2'b00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 2'b00;
    req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0; req_is_wr = 1'b0; req_from_dn = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state: outputs low, palette write not forwarded with both bits clear
    chk("R9", {dec_fwd, dec_blk, dec_range}, 4'b0000);
    do_req(32'h3C8, 1'b1, 1'b1, 1'b0);
    chk("R9", {dec_fwd, dec_blk, 2'b00}, 4'b0000);
    // R9 write in the same cycle as a request uses old bits
    cfg_we = 1'b1; cfg_wdata = 2'b01;
    req_valid = 1'b1; req_addr = 32'h3C0; req_is_io = 1'b1; req_is_wr = 1'b0; req_from_dn = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; cfg_model = 2'b01;
    chk("R9", {dec_fwd, dec_blk, dec_range}, 4'b0010);
    do_req(32'h3C0, 1'b1, 1'b0, 1'b0);
    chk("R9", {dec_fwd, dec_blk, dec_range}, 4'b1010);
    // R10 idle cycle clears outputs
    @(negedge clk);
    chk("R10", {dec_fwd, dec_blk, dec_range}, 4'b0000);

    for (int c = 0; c < 4; c++) begin
      cfg_write(c[1:0]);
      for (int a = 0; a < 1024; a++) begin
        for (int m = 0; m < 4; m++) begin
          do_req({16'h0, 6'((a * 7 + m * 13) % 64), 10'(a)}, 1'b1, m[0], m[1]);
        end
      end
      for (int k = 0; k < 256; k++) begin
        for (int m = 0; m < 4; m++) begin
          do_req(32'(k) * 32'h1000, 1'b0, m[0], m[1]);
          do_req(32'(k) * 32'h1000 + 32'hFFF, 1'b0, m[0], m[1]);
        end
      end
      for (int m = 0; m < 4; m++) begin
        do_req(32'h1000_A000, 1'b0, m[0], m[1]);
        do_req(32'h0000_03C8, 1'b0, m[0], m[1]);
        do_req(32'h0001_03C8, 1'b1, m[0], m[1]);
        do_req(32'hFFFF_03C0, 1'b1, m[0], m[1]);
        do_req(32'h000C_0000, 1'b0, m[0], m[1]);
      end
      @(negedge clk);
      chk("R10", {dec_fwd, dec_blk, dec_range}, 4'b0000);
    end
    finish_run();
  end
endmodule